// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block chooses which of a fixed set of page frames should be evicted next. It keeps one reference flag and one modify flag per frame. A hand pointer walks around the frames in a ring. An access to a frame sets its reference flag. A write also sets its modify flag. When a victim is requested, the hand examines one frame per clock cycle and stops at the first frame that qualifies. The selector reports that frame's index and whether it is dirty, then leaves the hand one position past it.

Two selection modes are available per request. In the basic mode, a frame whose reference flag is set is spared once: its flag is cleared and the hand moves on. In the ranked mode, frames are graded by the pair (reference, modify). The first frame in hand order inside the lowest non-empty grade is taken. The requester acknowledges the fill of the new page, which marks the chosen frame clean again. Writing the victim back to storage and updating mapping tables are handled by the requester.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset, `busy` and `vic_valid` are low, every reference and modify flag is clear, and the hand points at frame 0, so the first request returns frame 0 after one examination.
- R2: A cycle with `acc_valid` high sets the reference flag of frame `acc_idx`; if `acc_write` is also high, the modify flag of that frame is set as well.
- R3: In basic mode (`enh_mode`=0 at the request), the victim is the first frame from the hand onward whose reference flag is 0, and every frame passed over on the way has its reference flag cleared.
- R4: In basic mode, when every reference flag is set, the hand sweeps the full ring clearing every flag and selects the frame it started at.
- R5: After a victim is reported, the hand points at the frame following the victim, wrapping from frame N-1 to frame 0.
- R6: `vic_dirty` equals the modify flag of the victim at the moment it is chosen.
- R7: A `fill_ack` pulse clears the modify flag of the most recently reported victim.
- R8: In ranked mode (`enh_mode`=1), grade order is (0,0) before (0,1) before (1,0) before (1,1), written as (reference, modify). The victim is the first frame in hand order in the lowest grade present, and no reference flag is cleared while a (0,0) or (0,1) frame exists.
- R9: In ranked mode, if no (0,0) or (0,1) frame exists after two full passes, all reference flags are cleared together. The search then continues and returns the first former (1,0) frame, or else the first (1,1) frame, within 4N examinations.
- R10: `busy` is high from the cycle after an accepted request until the victim is reported. `vic_valid` is a one-cycle pulse that never coincides with `busy`. A request made while `busy` is high is ignored.
- R11: A basic-mode search holds `busy` for at most N+1 cycles, one cycle per frame examined.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enh_mode | input | 1 | Selection mode sampled with a request: 0 basic, 1 ranked |
| acc_valid | input | 1 | A frame is being accessed this cycle |
| acc_idx | input | IDX_W | Index of the accessed frame |
| acc_write | input | 1 | The access is a write |
| req_valid | input | 1 | Request a victim (accepted when idle) |
| fill_ack | input | 1 | The new page has been placed in the last victim |
| busy | output | 1 | A search is in progress |
| vic_valid | output | 1 | One-cycle strobe: victim fields are valid |
| vic_idx | output | IDX_W | Index of the chosen frame |
| vic_dirty | output | 1 | Chosen frame was modified and needs writeback |

## Verification
The bench builds the selector with five frames rather than the default eight. This makes the ring length a non-power-of-two, so the wrap from the last frame back to frame 0 is handled by comparison and not by counter overflow. With five frames, a full sweep takes six examinations and a worst-case ranked search takes sixteen. These short searches let directed sequences reach every corner: the all-set sweep, each ranked grade, the group clear after two failed passes, and the all-(1,1) case. Latencies are counted in busy cycles, so each expected examination count is checked exactly.

// File: rtl/clkv_pkg.sv
// Shared types for the clock victim selector.
package clkv_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;
endpackage

// File: rtl/clkv_flags.sv
// Per-frame reference and modify flag storage.
// Assumes: at most one frame is set per cycle; a set wins over a clear
// aimed at the same frame in the same cycle.
module clkv_flags #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic [IDX_W-1:0]      set_idx,
    input  logic                  set_wr,
    input  logic                  clr_ref_en,
    input  logic [IDX_W-1:0]      clr_ref_idx,
    input  logic                  clr_ref_all,
    input  logic                  clr_mod_en,
    input  logic [IDX_W-1:0]      clr_mod_idx,
    output logic [NUM_FRAMES-1:0] ref_q,
    output logic [NUM_FRAMES-1:0] mod_q
);

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
        logic hit_set;
        logic hit_clr_ref;
        logic hit_clr_mod;

        assign hit_set     = set_en && (set_idx == IDX_W'(g));
        assign hit_clr_ref = clr_ref_all || (clr_ref_en && (clr_ref_idx == IDX_W'(g)));
        assign hit_clr_mod = clr_mod_en && (clr_mod_idx == IDX_W'(g));

        // Reference flag: set on access, cleared by the hand.
        always_ff @(posedge clk) begin
            if (!rst_n)          ref_q[g] <= 1'b0;
            else if (hit_set)    ref_q[g] <= 1'b1;
            else if (hit_clr_ref) ref_q[g] <= 1'b0;
        end

        // Modify flag: set on write, cleared by fill acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)                 mod_q[g] <= 1'b0;
            else if (hit_set && set_wr) mod_q[g] <= 1'b1;
            else if (hit_clr_mod)       mod_q[g] <= 1'b0;
        end
    end

    AST_SET_REF: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ref_q[$past(set_idx)]); // R2

    AST_SET_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && set_wr) |=> mod_q[$past(set_idx)]); // R2

    AST_FILL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mod_en && !(set_en && set_wr && set_idx == clr_mod_idx))
        |=> !mod_q[$past(clr_mod_idx)]); // R7

endmodule

// File: rtl/clkv_scan.sv
// Hand pointer and search sequencer. Examines one frame per cycle.
// Basic mode: skip and clear frames with the reference flag set.
// Ranked mode: pass p looks for class {0, p[0]}; after passes 0 and 1
// fail, all reference flags clear together, so passes 2 and 3 find the
// former (1,0) and (1,1) frames. Assumes NUM_FRAMES >= 2.
module clkv_scan
    import clkv_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = $clog2(NUM_FRAMES),
    parameter int STEP_W     = $clog2(NUM_FRAMES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  mode_enh,
    input  logic [NUM_FRAMES-1:0] ref_q,
    input  logic [NUM_FRAMES-1:0] mod_q,
    output logic                  clr_ref_en,
    output logic [IDX_W-1:0]      clr_ref_idx,
    output logic                  clr_ref_all,
    output logic                  busy,
    output logic                  vic_valid,
    output logic [IDX_W-1:0]      vic_idx,
    output logic                  vic_dirty
);

    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_FRAMES - 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_FRAMES - 1);
    localparam int                CNT_W     = $clog2(4 * NUM_FRAMES + 2);

    scan_state_e       state_q;
    logic [IDX_W-1:0]  hand_q;
    logic [IDX_W-1:0]  hand_nxt;
    logic              mode_q;
    logic [1:0]        pass_q;
    logic [STEP_W-1:0] step_q;
    logic              cur_ref;
    logic              cur_mod;
    logic              scanning;
    logic              hit;
    logic              last_step;

    // Decode the frame under the hand and decide the outcome this cycle.
    always_comb begin
        cur_ref   = ref_q[hand_q];
        cur_mod   = mod_q[hand_q];
        scanning  = (state_q == ST_SCAN);
        last_step = (step_q == LAST_STEP);
        hand_nxt  = (hand_q == LAST_IDX) ? '0 : hand_q + 1'b1;
        if (mode_q) hit = scanning && ({cur_ref, cur_mod} == {1'b0, pass_q[0]});
        else        hit = scanning && !cur_ref;
    end

    assign clr_ref_en  = scanning && !mode_q && cur_ref;
    assign clr_ref_idx = hand_q;
    assign clr_ref_all = scanning && mode_q && !hit && last_step && (pass_q == 2'd1);
    assign busy        = scanning;

    // Sequencer: accept requests, walk the hand, report the victim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            hand_q    <= '0;
            mode_q    <= 1'b0;
            pass_q    <= '0;
            step_q    <= '0;
            vic_valid <= 1'b0;
            vic_idx   <= '0;
            vic_dirty <= 1'b0;
        end else begin
            vic_valid <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (req) begin
                    state_q <= ST_SCAN;
                    mode_q  <= mode_enh;
                    pass_q  <= '0;
                    step_q  <= '0;
                end
            end else begin
                hand_q <= hand_nxt;
                if (hit) begin
                    state_q   <= ST_IDLE;
                    vic_valid <= 1'b1;
                    vic_idx   <= hand_q;
                    vic_dirty <= cur_mod;
                end else if (last_step) begin
                    step_q <= '0;
                    pass_q <= pass_q + 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    // Examination counter for bound checks.
    logic [CNT_W-1:0] exam_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || !scanning) exam_cnt <= '0;
        else                     exam_cnt <= exam_cnt + 1'b1;
    end

    AST_BASIC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && !mode_q) |-> (exam_cnt <= CNT_W'(NUM_FRAMES))); // R11

    AST_RANKED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && mode_q) |-> (exam_cnt < CNT_W'(4 * NUM_FRAMES))); // R9

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |=> !vic_valid); // R10

    AST_NO_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !vic_valid); // R10

    AST_HAND_PAST: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |-> (hand_q == ((vic_idx == LAST_IDX) ? '0 : vic_idx + 1'b1))); // R5

    AST_BASIC_CLEAN_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_valid && !mode_q) |-> !ref_q[vic_idx]); // R3

endmodule

// File: rtl/clock_victim_sel.sv
// Top of the clock victim selector: flag storage plus search sequencer.
// Remembers the last reported victim so a fill acknowledge can mark it
// clean. Assumes the requester waits for vic_valid before fill_ack.
module clock_victim_sel #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enh_mode,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic             acc_write,
    input  logic             req_valid,
    input  logic             fill_ack,
    output logic             busy,
    output logic             vic_valid,
    output logic [IDX_W-1:0] vic_idx,
    output logic             vic_dirty
);

    logic [NUM_FRAMES-1:0] ref_q;
    logic [NUM_FRAMES-1:0] mod_q;
    logic                  clr_ref_en;
    logic [IDX_W-1:0]      clr_ref_idx;
    logic                  clr_ref_all;
    logic [IDX_W-1:0]      last_vic_q;

    // Hold the index of the most recent victim for the fill acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_vic_q <= '0;
        else if (vic_valid) last_vic_q <= vic_idx;
    end

    clkv_flags #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W)
    ) flags_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (acc_valid),
        .set_idx     (acc_idx),
        .set_wr      (acc_write),
        .clr_ref_en  (clr_ref_en),
        .clr_ref_idx (clr_ref_idx),
        .clr_ref_all (clr_ref_all),
        .clr_mod_en  (fill_ack),
        .clr_mod_idx (last_vic_q),
        .ref_q       (ref_q),
        .mod_q       (mod_q)
    );

    clkv_scan #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W)
    ) scan_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req_valid),
        .mode_enh    (enh_mode),
        .ref_q       (ref_q),
        .mod_q       (mod_q),
        .clr_ref_en  (clr_ref_en),
        .clr_ref_idx (clr_ref_idx),
        .clr_ref_all (clr_ref_all),
        .busy        (busy),
        .vic_valid   (vic_valid),
        .vic_idx     (vic_idx),
        .vic_dirty   (vic_dirty)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy && !vic_valid)); // R1

endmodule

// File: tb/clock_victim_sel_tb_top.sv
// Directed bench for the clock victim selector, five frames.
module clock_victim_sel_tb_top;

    localparam int N     = 5;
    localparam int IDX_W = $clog2(N);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enh_mode = 1'b0;
    logic             acc_valid = 1'b0;
    logic [IDX_W-1:0] acc_idx = '0;
    logic             acc_write = 1'b0;
    logic             req_valid = 1'b0;
    logic             fill_ack = 1'b0;
    logic             busy;
    logic             vic_valid;
    logic [IDX_W-1:0] vic_idx;
    logic             vic_dirty;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    clock_victim_sel #(.NUM_FRAMES(N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enh_mode  (enh_mode),
        .acc_valid (acc_valid),
        .acc_idx   (acc_idx),
        .acc_write (acc_write),
        .req_valid (req_valid),
        .fill_ack  (fill_ack),
        .busy      (busy),
        .vic_valid (vic_valid),
        .vic_idx   (vic_idx),
        .vic_dirty (vic_dirty)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic touch(input int idx, input bit wr);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_idx   = IDX_W'(idx);
        acc_write = wr;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    task automatic do_fill();
        @(negedge clk);
        fill_ack = 1'b1;
        @(negedge clk);
        fill_ack = 1'b0;
    endtask

    // Request a victim; optionally repeat the request while busy.
    task automatic do_req(input bit mode, input int exp_idx, input int exp_dirty,
                          input int exp_busy, input bit poke, input string tag);
        int  nbusy = 0;
        bit  seen = 1'b0;
        @(negedge clk);
        enh_mode  = mode;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = poke;
        for (int i = 0; i < 40; i++) begin
            if (vic_valid) begin
                seen = 1'b1;
                break;
            end
            if (busy) nbusy++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk({tag, " seen"}, seen, 1);
        chk({tag, " idx"}, vic_idx, exp_idx);
        chk({tag, " dirty"}, vic_dirty, exp_dirty);
        chk({tag, " busy cycles"}, nbusy, exp_busy);
        chk({tag, " R10 busy low at strobe"}, busy, 0);
        @(negedge clk);
        chk({tag, " R10 strobe one cycle"}, vic_valid, 0);
        if (poke) begin
            for (int i = 0; i < 4; i++) begin
                chk({tag, " R10 no second search"}, busy | vic_valid, 0);
                @(negedge clk);
            end
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 busy after reset", busy, 0);
        chk("R1 valid after reset", vic_valid, 0);
        do_req(1'b0, 0, 0, 1, 1'b0, "R1 first pick frame 0 R11");
    endtask

    task automatic t_basic();
        touch(1, 1'b0);
        touch(2, 1'b0);
        do_req(1'b0, 3, 0, 3, 1'b0, "R2 R3 skip referenced");
        do_req(1'b0, 4, 0, 1, 1'b0, "R5 hand past victim");
        do_req(1'b0, 0, 0, 1, 1'b0, "R5 wrap to frame 0");
        do_req(1'b0, 1, 0, 1, 1'b0, "R3 skipped flag cleared");
    endtask

    task automatic t_dirty();
        touch(2, 1'b1);
        do_req(1'b0, 3, 0, 2, 1'b0, "R3 written frame spared");
        do_req(1'b0, 4, 0, 1, 1'b0, "R3 step 4");
        do_req(1'b0, 0, 0, 1, 1'b0, "R3 step 0");
        do_req(1'b0, 1, 0, 1, 1'b0, "R3 step 1");
        do_req(1'b0, 2, 1, 1, 1'b0, "R6 dirty victim");
        do_fill();
        touch(0, 1'b0);
        touch(1, 1'b0);
        touch(3, 1'b0);
        touch(4, 1'b0);
        do_req(1'b0, 2, 0, 5, 1'b0, "R7 fill clears modify");
    endtask

    task automatic t_all_set();
        for (int i = 0; i < N; i++) touch(i, 1'b0);
        do_req(1'b0, 3, 0, N + 1, 1'b0, "R4 R11 full sweep");
        do_req(1'b0, 4, 0, 1, 1'b0, "R4 sweep cleared flags");
        for (int i = 0; i < N; i++) touch(i, 1'b0);
        do_req(1'b0, 0, 0, N + 1, 1'b1, "R10 request while busy");
    endtask

    task automatic t_ranked();
        do_reset();
        touch(0, 1'b1);
        touch(1, 1'b0);
        do_req(1'b1, 2, 0, 3, 1'b0, "R8 class 00 first");
        do_reset();
        for (int i = 0; i < N; i++) touch(i, 1'b1);
        do_req(1'b0, 0, 1, N + 1, 1'b0, "R6 prep sweep dirty");
        touch(1, 1'b0);
        touch(3, 1'b0);
        do_req(1'b1, 2, 1, 7, 1'b0, "R8 class 01 after empty 00");
    endtask

    task automatic t_ranked_clear();
        do_reset();
        touch(0, 1'b1);
        touch(1, 1'b1);
        touch(2, 1'b0);
        touch(3, 1'b0);
        touch(4, 1'b0);
        do_req(1'b1, 2, 0, 13, 1'b0, "R9 former 10 after group clear");
        do_req(1'b0, 3, 0, 1, 1'b0, "R9 group clear visible");
        do_reset();
        for (int i = 0; i < N; i++) touch(i, 1'b1);
        do_req(1'b1, 0, 1, 16, 1'b0, "R9 all 11 worst case");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_basic();
                t_dirty();
                t_all_set();
                t_ranked();
                t_ranked_clear();
            end
            begin
                repeat (20000) @(posedge clk);
                chk("watchdog expired", 1, 0);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule